// File: doc/BRIEF.md
# Code and External-Data Space Router

This block sits between an 8-bit microcontroller core and its memories and decides, access by access, where each one goes. A program fetch goes to the on-chip program ROM or to the expansion bus. An external-data transfer (a MOVX read or write) goes to a 1 kB on-chip data SRAM or to the expansion bus. Two small configuration registers, written through a special-function-register (SFR) write port, control the choice. One sets how much of the code space is on chip. The other switches the on-chip data window in or out. A pin that forces external fetches overrides the code-size setting.

The core offers one request at a time, with an address, a code/data flag, a write flag and write data. An access routed on chip raises a ROM or RAM select for one cycle, with the latched address. An access routed off chip runs a multiplexed bus cycle. In the first cycle an address latch strobe is high, the low address byte is on the shared 8-bit port and the high byte is on a second port. In the second cycle the shared port carries the data, and exactly one active-low strobe is asserted: program-store enable for a fetch, write or read strobe for MOVX. A done pulse follows, and read data is captured from the bus at the end of the strobe cycle. Each access is routed with the configuration in force when it is accepted, so a register write never changes a bus cycle that is already running.

Top module: `mem_space_router`

## Requirements
- R1: After reset the code-size setting is 16 kB and the data window is off. `reqReady` is 1, `romSel`, `ramSel`, `aleOut`, `busOe` and `accDone` are 0, and `progStoreN`, `rdN` and `wrN` are 1.
- R2: A fetch accepted (`reqValid` and `reqReady` high at a rising edge) below the internal code limit makes `romSel` and `accDone` high for exactly the next cycle, with `memAddr` equal to the fetch address and no bus strobe active.
- R3: While `codeIntEn` is 0, every fetch runs an external bus cycle, whatever the code-size setting.
- R4: The code-size setting is bits 2:0 of SFR address C2h, coded as 0=0 kB, 1=1 kB, 2=2 kB, 3=4 kB, 4=8 kB and 5=16 kB. Codes 6 and 7 mean 16 kB. A fetch at or above the limit goes external.
- R5: The data-window setting is bits 1:0 of SFR address C4h. With code 01, MOVX addresses 0000h–03FFh give a one-cycle `ramSel` with `accDone`, and addresses from 0400h up go external.
- R6: With data-window codes 00, 10 or 11, and after reset, every MOVX address goes external.
- R7: An external access accepted at edge k has `aleOut`=1, `busOe`=1, `busOut`=address[7:0] and `busHi`=address[15:8] in cycle k+1. Cycle k+2 is the strobe cycle, with `busHi` still held. `accDone`=1 in cycle k+3, and `reqReady` returns in cycle k+4.
- R8: In the strobe cycle exactly one strobe is low. `progStoreN` goes low for a fetch, with `busOe`=0. `wrN` goes low for a MOVX write, with `busOe`=1 and `busOut`=write data. `rdN` goes low for a MOVX read, with `busOe`=0. At most one of `romSel`, `ramSel` and the three strobes is active at any time.
- R9: For an external fetch or MOVX read, `busIn` is sampled at the edge that ends the strobe cycle and appears on `rdData` from the done cycle on. It holds until the next such capture and is 0 after reset.
- R10: A request is taken only in a cycle with `reqReady`=1. `reqReady` is 0 for the 1 busy cycle of an on-chip access and the 3 busy cycles of an external one, and `reqValid` has no effect during those cycles.
- R11: A configuration write applies to requests accepted from the following cycle on. A request accepted at the same edge as the write uses the old setting, and a bus cycle already under way is not altered.
- R12: SFR writes to any address other than C2h and C4h change neither setting. Bits 7:3 of a C2h write and bits 7:2 of a C4h write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sfrWrEn | input | 1 | SFR write enable |
| sfrAddr | input | 8 | SFR write address |
| sfrWrData | input | 8 | SFR write data |
| codeIntEn | input | 1 | 0 forces every fetch to the external bus |
| reqValid | input | 1 | Access request |
| reqIsCode | input | 1 | 1 = program fetch, 0 = MOVX |
| reqIsWrite | input | 1 | MOVX write (ignored for fetches) |
| reqAddr | input | 16 | Access address |
| reqWrData | input | 8 | MOVX write data |
| reqReady | output | 1 | Block idle, request can be taken |
| accDone | output | 1 | Access complete pulse |
| romSel | output | 1 | On-chip program ROM select |
| ramSel | output | 1 | On-chip data SRAM select |
| memAddr | output | 16 | Latched address for the on-chip arrays |
| rdData | output | 8 | Data captured from the external bus |
| busOut | output | 8 | Multiplexed low address / data out |
| busOe | output | 1 | Drive enable for `busOut` |
| busIn | input | 8 | Multiplexed port input |
| busHi | output | 8 | High address byte |
| aleOut | output | 1 | Address latch strobe |
| progStoreN | output | 1 | Active-low program-store enable |
| rdN | output | 1 | Active-low external read strobe |
| wrN | output | 1 | Active-low external write strobe |

## Verification
For an access accepted at edge k, the on-chip selects and their done pulse are due in cycle k+1. An external access shows the address phase in cycle k+1, the strobe in k+2 and the done pulse with captured read data in k+3, and it is ready again in k+4. A configuration write counts from the edge after it. The bench's behavioural model advances on the same edges from the same inputs. Every output is compared with the model at each falling edge, when all of them are stable. Directed routing checks note whether a select was seen during each access, so boundary addresses and same-edge write/request races are judged by what the ports showed.

// File: rtl/memroute_pkg.sv
package memroute_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INT,
    PH_ALE,
    PH_STB,
    PH_FIN
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic capRd;
    logic driveAddr;
    logic driveData;
    logic busActive;
  } ctlStrobe_t;

  // code-size code to byte limit; codes above 5 saturate at 16 units
  function automatic int unsigned romLimitBytes(input logic [2:0] code,
                                                input int unsigned unitBytes);
    if (code == 3'd0)
      return 0;
    else if (code > 3'd5)
      return unitBytes << 4;
    else
      return unitBytes << (code - 3'd1);
  endfunction

endpackage

// File: rtl/mem_space_router_dp.sv
module mem_space_router_dp
  import memroute_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SFR_AW = 8,
  parameter logic [SFR_AW-1:0] SIZE_SFR = 8'hC2,
  parameter logic [SFR_AW-1:0] WIN_SFR = 8'hC4,
  parameter logic [2:0] SIZE_RST = 3'd5,
  parameter logic [1:0] WIN_ON = 2'b01,
  parameter int unsigned ROM_UNIT = 1024,
  parameter int unsigned DRAM_BYTES = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic sfrWrEn,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [DATA_W-1:0] sfrWrData,
  input  logic codeIntEn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic reqIsCode,
  input  logic reqIsWrite,
  input  ctlStrobe_t strobe,
  input  logic [DATA_W-1:0] busIn,
  output logic routeInt,
  output logic [ADDR_W-1:0] addrQ,
  output logic isCodeQ,
  output logic isWriteQ,
  output logic [DATA_W-1:0] busOut,
  output logic busOe,
  output logic [ADDR_W-DATA_W-1:0] busHi,
  output logic [DATA_W-1:0] rdData
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [2:0] sizeCode;
  logic [1:0] winCode;
  logic [DATA_W-1:0] wrDataQ;
  logic codeHit;
  logic dataHit;

  // configuration registers, only low bits are kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeCode <= SIZE_RST;
      winCode  <= 2'b00;
    end else if (sfrWrEn) begin
      if (sfrAddr == SIZE_SFR) sizeCode <= sfrWrData[2:0];
      if (sfrAddr == WIN_SFR)  winCode  <= sfrWrData[1:0];
    end
  end

  // routing decision from settings in force this cycle
  always_comb begin
    codeHit  = codeIntEn && (32'(reqAddr) < romLimitBytes(sizeCode, ROM_UNIT));
    dataHit  = (winCode == WIN_ON) && (32'(reqAddr) < DRAM_BYTES);
    routeInt = reqIsCode ? codeHit : dataHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      isCodeQ  <= 1'b0;
      isWriteQ <= 1'b0;
      wrDataQ  <= '0;
    end else if (strobe.latchReq) begin
      addrQ    <= reqAddr;
      isCodeQ  <= reqIsCode;
      isWriteQ <= reqIsWrite & ~reqIsCode;
      wrDataQ  <= reqWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobe.capRd) rdData <= busIn;
  end

  always_comb begin
    busOe  = strobe.driveAddr | strobe.driveData;
    busOut = strobe.driveData ? wrDataQ : addrQ[DATA_W-1:0];
    busHi  = strobe.busActive ? addrQ[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
  end

  assert_size_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(sfrWrEn && sfrAddr == SIZE_SFR) |=> $stable(sizeCode));

  assert_win_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(sfrWrEn && sfrAddr == WIN_SFR) |=> $stable(winCode));

  // upper data bits must not leak into either setting
  assert_upper_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    (sfrWrEn && sfrAddr == WIN_SFR && sfrWrData[DATA_W-1:3] != '0)
      |=> winCode == $past(sfrWrData[1:0]));

  assert_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capRd |=> rdData == $past(busIn));

endmodule

// File: rtl/mem_space_router_ctl.sv
module mem_space_router_ctl
  import memroute_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqIsCode,
  input  logic codeIntEn,
  input  logic routeInt,
  input  logic isCodeQ,
  input  logic isWriteQ,
  output ctlStrobe_t strobe,
  output logic reqReady,
  output logic accDone,
  output logic romSel,
  output logic ramSel,
  output logic aleOut,
  output logic progStoreN,
  output logic rdN,
  output logic wrN
);

  phase_t phase;
  phase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (reqValid) phaseNext = routeInt ? PH_INT : PH_ALE;
      PH_INT:  phaseNext = PH_IDLE;
      PH_ALE:  phaseNext = PH_STB;
      PH_STB:  phaseNext = PH_FIN;
      PH_FIN:  phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strobe.latchReq  = (phase == PH_IDLE) && reqValid;
    strobe.capRd     = (phase == PH_STB) && (isCodeQ || !isWriteQ);
    strobe.driveAddr = (phase == PH_ALE);
    strobe.driveData = (phase == PH_STB) && !isCodeQ && isWriteQ;
    strobe.busActive = (phase == PH_ALE) || (phase == PH_STB);
  end

  always_comb begin
    reqReady   = (phase == PH_IDLE);
    accDone    = (phase == PH_INT) || (phase == PH_FIN);
    romSel     = (phase == PH_INT) && isCodeQ;
    ramSel     = (phase == PH_INT) && !isCodeQ;
    aleOut     = (phase == PH_ALE);
    progStoreN = !((phase == PH_STB) && isCodeQ);
    rdN        = !((phase == PH_STB) && !isCodeQ && !isWriteQ);
    wrN        = !((phase == PH_STB) && !isCodeQ && isWriteQ);
  end

  assert_single_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romSel, ramSel, ~progStoreN, ~rdN, ~wrN}));

  assert_ale_then_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |=> (!progStoreN || !rdN || !wrN));

  assert_pin_forces_external_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchReq && reqIsCode && !codeIntEn) |=> (aleOut && !romSel));

  assert_busy_no_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> !romSel && !ramSel || $past(phase == PH_INT) == 1'b0);

  assert_done_after_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!progStoreN || !rdN || !wrN) |=> (accDone && !reqReady));

endmodule

// File: rtl/mem_space_router.sv
module mem_space_router
  import memroute_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SFR_AW = 8,
  parameter int unsigned ROM_UNIT = 1024,
  parameter int unsigned DRAM_BYTES = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic sfrWrEn,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [DATA_W-1:0] sfrWrData,
  input  logic codeIntEn,
  input  logic reqValid,
  input  logic reqIsCode,
  input  logic reqIsWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  output logic reqReady,
  output logic accDone,
  output logic romSel,
  output logic ramSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] busOut,
  output logic busOe,
  input  logic [DATA_W-1:0] busIn,
  output logic [ADDR_W-DATA_W-1:0] busHi,
  output logic aleOut,
  output logic progStoreN,
  output logic rdN,
  output logic wrN
);

  ctlStrobe_t strobe;
  logic routeInt;
  logic isCodeQ;
  logic isWriteQ;

  mem_space_router_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SFR_AW(SFR_AW),
    .ROM_UNIT(ROM_UNIT), .DRAM_BYTES(DRAM_BYTES)
  ) dp (
    .clk(clk), .rstN(rstN),
    .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr), .sfrWrData(sfrWrData),
    .codeIntEn(codeIntEn),
    .reqAddr(reqAddr), .reqWrData(reqWrData),
    .reqIsCode(reqIsCode), .reqIsWrite(reqIsWrite),
    .strobe(strobe), .busIn(busIn),
    .routeInt(routeInt), .addrQ(memAddr),
    .isCodeQ(isCodeQ), .isWriteQ(isWriteQ),
    .busOut(busOut), .busOe(busOe), .busHi(busHi), .rdData(rdData)
  );

  mem_space_router_ctl ctl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqIsCode(reqIsCode), .codeIntEn(codeIntEn),
    .routeInt(routeInt), .isCodeQ(isCodeQ), .isWriteQ(isWriteQ),
    .strobe(strobe), .reqReady(reqReady), .accDone(accDone),
    .romSel(romSel), .ramSel(ramSel), .aleOut(aleOut),
    .progStoreN(progStoreN), .rdN(rdN), .wrN(wrN)
  );

  assert_ram_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    ramSel |-> (32'(memAddr) < DRAM_BYTES));

endmodule

// File: tb/mem_space_router_test.sv
module mem_space_router_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sfrWrEn = 1'b0;
  logic [7:0] sfrAddr = '0;
  logic [7:0] sfrWrData = '0;
  logic codeIntEn = 1'b1;
  logic reqValid = 1'b0;
  logic reqIsCode = 1'b0;
  logic reqIsWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqWrData = '0;
  logic [7:0] busIn = 8'h00;
  logic reqReady, accDone, romSel, ramSel, busOe, aleOut, progStoreN, rdN, wrN;
  logic [15:0] memAddr;
  logic [7:0] rdData, busOut, busHi;

  mem_space_router uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit sawInt = 0;

  // behavioural reference state
  int mPhase = 0;  // 0 idle,1 on-chip,2 address,3 strobe,4 done
  int mSize = 5;
  int mWin = 0;
  logic [15:0] mAddr = '0;
  logic mCode = 0, mWr = 0;
  logic [7:0] mData = '0, mRd = '0;

  function automatic int limitOf(int code);
    case (code)
      0: return 0;
      1: return 1024;
      2: return 2048;
      3: return 4096;
      4: return 8192;
      default: return 16384;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mSize = 5; mWin = 0; mRd = '0;
      mAddr = '0; mCode = 0; mWr = 0; mData = '0;
    end else begin
      case (mPhase)
        0: if (reqValid) begin
             bit inside_;
             mAddr = reqAddr; mCode = reqIsCode; mWr = reqIsWrite && !reqIsCode;
             mData = reqWrData;
             if (reqIsCode) inside_ = codeIntEn && (int'(reqAddr) < limitOf(mSize));
             else           inside_ = (mWin == 1) && (int'(reqAddr) < 1024);
             mPhase = inside_ ? 1 : 2;
           end
        1: mPhase = 0;
        2: mPhase = 3;
        3: begin if (mCode || !mWr) mRd = busIn; mPhase = 4; end
        default: mPhase = 0;
      endcase
      if (sfrWrEn && sfrAddr == 8'hC2) mSize = int'(sfrWrData[2:0]);
      if (sfrWrEn && sfrAddr == 8'hC4) mWin = int'(sfrWrData[1:0]);
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit stb;
      stb = (mPhase == 3);
      if (romSel || ramSel) sawInt = 1;
      check("R10 reqReady", 16'(reqReady), 16'(mPhase == 0));
      check("R2 romSel", 16'(romSel), 16'(mPhase == 1 && mCode));
      check("R5 ramSel", 16'(ramSel), 16'(mPhase == 1 && !mCode));
      if (mPhase == 1) check("R2 memAddr", memAddr, mAddr);
      check("R7 accDone", 16'(accDone), 16'(mPhase == 1 || mPhase == 4));
      check("R7 aleOut", 16'(aleOut), 16'(mPhase == 2));
      check("R7 busOe", 16'(busOe), 16'(mPhase == 2 || (stb && !mCode && mWr)));
      if (mPhase == 2) check("R7 busOut addr", 16'(busOut), 16'(mAddr[7:0]));
      if (stb && !mCode && mWr) check("R8 busOut data", 16'(busOut), 16'(mData));
      check("R7 busHi", 16'(busHi), (mPhase == 2 || stb) ? 16'(mAddr[15:8]) : 16'h0);
      check("R8 progStoreN", 16'(progStoreN), 16'(!(stb && mCode)));
      check("R8 rdN", 16'(rdN), 16'(!(stb && !mCode && !mWr)));
      check("R8 wrN", 16'(wrN), 16'(!(stb && !mCode && mWr)));
      check("R9 rdData", 16'(rdData), 16'(mRd));
    end
  end

  task automatic drive(input logic v, input logic c, input logic w, input logic [15:0] a,
                       input logic [7:0] d, input logic se, input logic [7:0] sa,
                       input logic [7:0] sd);
    reqValid = v; reqIsCode = c; reqIsWrite = w; reqAddr = a; reqWrData = d;
    sfrWrEn = se; sfrAddr = sa; sfrWrData = sd;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(0, 0, 0, 16'h0, 8'h0, 0, 8'h0, 8'h0);
  endtask

  task automatic settle();
    while (mPhase != 0) idle();
    idle();
  endtask

  task automatic sfr(input logic [7:0] a, input logic [7:0] d);
    drive(0, 0, 0, 16'h0, 8'h0, 1, a, d);
  endtask

  // one access, then compare whether an on-chip select was seen
  task automatic access(input string tag, input logic c, input logic w,
                        input logic [15:0] a, input logic [7:0] d, input bit expInt);
    sawInt = 0;
    drive(1, c, w, a, d, 0, 8'h0, 8'h0);
    settle();
    check(tag, 16'(sawInt), 16'(expInt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 reqReady", 16'(reqReady), 16'h1);
    check("R1 strobes", {11'h0, aleOut, busOe, progStoreN, rdN, wrN}, 16'h0007);
    check("R1 selects", {13'h0, romSel, ramSel, accDone}, 16'h0);
    check("R1 rdData", 16'(rdData), 16'h0);
    rstN = 1'b1;
    idle();

    // R2 / R4 default 16 kB
    access("R2 fetch 0000 on chip", 1, 0, 16'h0000, 8'h0, 1);
    access("R2 fetch 3FFF on chip", 1, 0, 16'h3FFF, 8'h0, 1);
    access("R4 fetch 4000 external", 1, 0, 16'h4000, 8'h0, 0);

    // R4 every size code at its boundary
    for (int code = 0; code < 8; code++) begin
      int lim;
      lim = limitOf(code);
      sfr(8'hC2, 8'(code));
      if (lim > 0) access("R4 below limit", 1, 0, 16'(lim - 1), 8'h0, 1);
      access("R4 at limit", 1, 0, 16'(lim), 8'h0, 0);
    end
    sfr(8'hC2, 8'hF5);  // upper bits ignored (R12)
    access("R12 size upper bits ignored", 1, 0, 16'h3FFF, 8'h0, 1);

    // R3 pin override
    codeIntEn = 1'b0;
    access("R3 pin low fetch 0000", 1, 0, 16'h0000, 8'h0, 0);
    access("R3 pin low fetch 1000", 1, 0, 16'h1000, 8'h0, 0);
    codeIntEn = 1'b1;

    // R6 window off codes
    busIn = 8'h3C;
    access("R6 reset code MOVX 0000", 0, 0, 16'h0000, 8'h0, 0);
    check("R9 read data captured", 16'(rdData), 16'h003C);
    sfr(8'hC4, 8'h02);
    access("R6 code 10 MOVX 0000", 0, 0, 16'h0000, 8'h0, 0);
    sfr(8'hC4, 8'h03);
    access("R6 code 11 MOVX 0100", 0, 1, 16'h0100, 8'h55, 0);

    // R5 window on, upper bits set
    sfr(8'hC4, 8'hF1);
    access("R5 MOVX 03FF on chip", 0, 0, 16'h03FF, 8'h0, 1);
    access("R5 MOVX write 0000 on chip", 0, 1, 16'h0000, 8'h11, 1);
    access("R5 MOVX 0400 external", 0, 0, 16'h0400, 8'h0, 0);

    // R12 other addresses
    sfr(8'hC3, 8'h00);
    sfr(8'hC5, 8'h00);
    access("R12 C3 write no size change", 1, 0, 16'h3FFF, 8'h0, 1);
    access("R12 C5 write no window change", 0, 0, 16'h0000, 8'h0, 1);

    // R7 / R8 external write and read with data
    busIn = 8'hA7;
    access("R8 ext write 1234", 0, 1, 16'h1234, 8'hA5, 0);
    check("R9 write keeps rdData", 16'(rdData), 16'h003C);
    access("R9 ext fetch 9ABC", 1, 0, 16'h9ABC, 8'h0, 0);
    check("R9 fetch byte captured", 16'(rdData), 16'h00A7);

    // R11 same-edge write uses old setting
    sawInt = 0;
    drive(1, 1, 0, 16'h3FFF, 8'h0, 1, 8'hC2, 8'h00);
    settle();
    check("R11 same edge old size", 16'(sawInt), 16'h1);
    access("R11 next access new size", 1, 0, 16'h0000, 8'h0, 0);
    sfr(8'hC2, 8'h05);
    // R11 write during a running bus cycle
    sfr(8'hC4, 8'h00);
    sawInt = 0;
    drive(1, 0, 0, 16'h0010, 8'h0, 0, 8'h0, 8'h0);
    drive(0, 0, 0, 16'h0, 8'h0, 1, 8'hC4, 8'h01);
    settle();
    check("R11 running cycle unchanged", 16'(sawInt), 16'h0);
    access("R11 later access on chip", 0, 0, 16'h0010, 8'h0, 1);

    // R10 request held across busy cycles
    busIn = 8'h5E;
    for (int i = 0; i < 9; i++) drive(1, 1, 0, 16'h8000 + 16'(i), 8'h0, 0, 8'h0, 8'h0);
    settle();
    check("R10 back-to-back capture", 16'(rdData), 16'h005E);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule